// File: doc/BRIEF.md
# Dynamic-Width External Bus Controller

This block turns read and write requests from a 16-bit core into cycles on a multiplexed address/data bus. One clock period of the block stands for one oscillator period. A request carries a word address, two byte enables, write data and a flag that marks instruction fetches. The block decides whether the access goes on-chip or off-chip. An off-chip access runs one bus cycle, or two byte cycles when the bus is narrow. The core sees a one-clock acknowledge, and read data is valid in the same clock.

The width of each cycle is decided by the cycle itself. When dynamic width is enabled, a width pin is sampled early in the cycle. Otherwise every cycle is one byte wide. Configuration inputs choose the meaning of three pins: a short address-latch pulse or a cycle-long address-valid level; a common write strobe or an even-byte write strobe; and a high-lane enable or an odd-byte write strobe. A hold handshake hands the bus to another master between transactions. While the bus is held, the block reports whether it has an off-chip access waiting.

Top module: `xbus_ctl`

## Requirements
- R1: With `cfg_dyn_width`=0 every cycle is 8 bits wide. A request with both byte enables set (`req_be`=2'b11; bit 0 is the even byte, bit 1 the odd byte) runs as two byte cycles: the even address first, then the odd address. `ack_o` comes after the second cycle, and `rdata_o` carries the odd byte in [15:8] and the even byte in [7:0]. A byte cycle always moves its data on `ad_o/ad_i[7:0]`, and `bhe_n_o` stays high in high-lane-enable mode.
- R2: With `cfg_dyn_width`=1, `buswidth_i` is sampled in the second clock of each cycle. If it is high, the cycle is 16 bits wide and a word request completes in one cycle.
- R3: With `cfg_dyn_width`=1 and `buswidth_i` low at the sample point, the cycle is 8 bits wide and a word request is split exactly as in R1.
- R4: A cycle lasts 4 clocks. `ready_i` is sampled in the third clock. Each low sample adds 2 clocks, after which `ready_i` is sampled again, with no limit. For a read, `rd_n_o` is low in clocks 2 to 4 plus the added clocks. A zero-wait single-cycle request sees `ack_o` 5 clocks after the first clock in which `req_valid` is seen.
- R5: With `cfg_adv`=0, `addr_strb_o` is high only in the first clock of each cycle. With `cfg_adv`=1 it is low from the first clock of a cycle until READY is accepted, and high in the cycle's last clock and between cycles. Either way the address is on `ad_o` in the first clock, with bit 0 set when the cycle moves the odd byte.
- R6: Write strobes are low in clocks 3 and 4 of a write cycle, plus any wait clocks. With `cfg_wrl`=0, `wr_n_o` goes low on every write cycle. With `cfg_wrl`=1 it goes low only when the cycle writes the even byte.
- R7: With `cfg_wrh`=0, `bhe_n_o` goes low in a write cycle that drives the upper data lane, which happens only in 16-bit cycles. With `cfg_wrh`=1 it goes low only when the cycle writes the odd byte, on either width.
- R8: `inst_o` is high for every clock of an off-chip read with `req_inst`=1. It is low for data reads, for writes and outside off-chip cycles.
- R9: With `ea_i`=1, requests to 16'h2000..16'h5FFF are served on-chip. `ack_o` comes one clock after the request is seen, with `int_hit_o`=1 and no bus activity. With `ea_i`=0 those addresses go off-chip with `int_hit_o`=0.
- R10: Data requests (`req_inst`=0) to 16'h0000..16'h01FF are served on-chip as in R9. Instruction fetches from that range always go off-chip.
- R11: `hold_i` is sampled only between transactions, never inside a cycle or between the two halves of a split word. While `hlda_o` is high, `ad_oe_o` is low, the strobes rest at their inactive levels, `weak_o` is high and no request is served.
- R12: `breq_o` is high only while `hlda_o` is high and `req_valid` presents an off-chip request.
- R13: `ack_o` is a single-clock pulse. `rd_n_o` and `wr_n_o` are never low together, and every strobe is inactive after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dyn_width | input | 1 | 1: width taken from `buswidth_i` per cycle; 0: always 8-bit |
| cfg_adv | input | 1 | 1: address-valid level on `addr_strb_o`; 0: address-latch pulse |
| cfg_wrl | input | 1 | 1: `wr_n_o` only for even-byte writes |
| cfg_wrh | input | 1 | 1: `bhe_n_o` is the odd-byte write strobe |
| ea_i | input | 1 | 1: 16'h2000..16'h5FFF served on-chip |
| req_valid | input | 1 | Request present, held until `ack_o` |
| req_we | input | 1 | 1: write |
| req_inst | input | 1 | 1: instruction fetch |
| req_addr | input | 16 | Word address (bit 0 ignored) |
| req_be | input | 2 | Byte enables, bit 0 even byte, nonzero |
| req_wdata | input | 16 | Write data |
| ack_o | output | 1 | One-clock completion pulse |
| int_hit_o | output | 1 | With `ack_o`: request served on-chip |
| rdata_o | output | 16 | Read data, valid with `ack_o` |
| ad_i | input | 16 | Bus data in |
| ad_o | output | 16 | Bus address/data out |
| ad_oe_o | output | 1 | Bus output enable |
| addr_strb_o | output | 1 | Address latch pulse or address-valid level |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write or even-byte write strobe, active low |
| bhe_n_o | output | 1 | High-lane enable or odd-byte write strobe, active low |
| inst_o | output | 1 | Instruction-fetch marker |
| buswidth_i | input | 1 | 1: 16-bit cycle requested |
| ready_i | input | 1 | 0: insert wait states |
| hold_i | input | 1 | Bus hold request |
| hlda_o | output | 1 | Bus released |
| breq_o | output | 1 | Off-chip access waiting during hold |
| weak_o | output | 1 | Strobes parked at weak inactive levels |

## Verification
The bench targets several risky cases. It checks the split of a word on a narrow bus, comparing the order of the two byte addresses and the lane each byte is taken from; a design that fetched the odd byte first, or stored it in the wrong half, returns swapped data. It counts strobe clocks under each pin encoding and for odd-only, even-only and both-byte writes, which catches a strobe that follows the wrong byte or the wrong lane. It holds READY low for 1 and 3 samples to expose an off-by-one in the wait length. It raises HOLD mid-cycle to catch a design that cuts a cycle short or grants the bus inside a transaction. It probes the edges of the on-chip ranges and the instruction-fetch exception, where a comparison slip would send an access to the wrong side.

// File: rtl/xbus_ctl.sv
module xbus_ctl #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] ROM_LO  = 16'h2000,
  parameter logic [AW-1:0] ROM_HI  = 16'h5FFF,
  parameter logic [AW-1:0] REG_TOP = 16'h01FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_dyn_width,
  input  logic          cfg_adv,
  input  logic          cfg_wrl,
  input  logic          cfg_wrh,
  input  logic          ea_i,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic          req_inst,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          ack_o,
  output logic          int_hit_o,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          addr_strb_o,
  output logic          rd_n_o,
  output logic          wr_n_o,
  output logic          bhe_n_o,
  output logic          inst_o,
  input  logic          buswidth_i,
  input  logic          ready_i,
  input  logic          hold_i,
  output logic          hlda_o,
  output logic          breq_o,
  output logic          weak_o
);
  localparam int BW = DW / 2;

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_P0, S_P1, S_P2, S_WA, S_WB, S_P3} st_t;

  st_t           st;
  logic [AW-1:0] c_addr;
  logic [1:0]    c_be;
  logic          c_we, c_inst, c_wide, c_second;
  logic [DW-1:0] c_wdata;

  wire req_int = (ea_i && req_addr >= ROM_LO && req_addr <= ROM_HI) ||
                 (!req_inst && req_addr <= REG_TOP);

  wire data_win = (st == S_P2) || (st == S_WA) || (st == S_WB) || (st == S_P3);
  wire strb_win = (st == S_P1) || data_win;
  wire in_cyc   = (st == S_P0) || strb_win;
  wire a0       = c_addr[0];
  wire even_wr  = c_wide ? c_be[0] : ~a0;
  wire odd_wr   = c_wide ? c_be[1] : a0;
  wire wr_win   = c_we && data_win;
  wire [BW-1:0] nbyte = a0 ? c_wdata[DW-1:BW] : c_wdata[BW-1:0];

  assign ad_oe_o     = (st == S_P0) || wr_win;
  assign ad_o        = (st == S_P0) ? c_addr
                     : (c_wide ? c_wdata : {c_wdata[DW-1:BW], nbyte});
  assign addr_strb_o = cfg_adv ? !(in_cyc && st != S_P3) : (st == S_P0);
  assign rd_n_o      = !(!c_we && strb_win);
  assign wr_n_o      = !(wr_win && (!cfg_wrl || even_wr));
  assign bhe_n_o     = !(wr_win && (cfg_wrh ? odd_wr : (c_wide && c_be[1])));
  assign inst_o      = in_cyc && !c_we && c_inst;
  assign hlda_o      = (st == S_HOLD);
  assign weak_o      = (st == S_HOLD);
  assign breq_o      = (st == S_HOLD) && req_valid && !req_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      c_addr    <= '0;
      c_be      <= '0;
      c_we      <= 1'b0;
      c_inst    <= 1'b0;
      c_wide    <= 1'b0;
      c_second  <= 1'b0;
      c_wdata   <= '0;
      rdata_o   <= '0;
      ack_o     <= 1'b0;
      int_hit_o <= 1'b0;
    end else begin
      ack_o     <= 1'b0;
      int_hit_o <= 1'b0;
      case (st)
        S_IDLE: begin
          if (hold_i) begin
            st <= S_HOLD;
          end else if (req_valid && !ack_o) begin
            if (req_int) begin
              ack_o     <= 1'b1;
              int_hit_o <= 1'b1;
            end else begin
              c_addr   <= {req_addr[AW-1:1], ~req_be[0]};
              c_be     <= req_be;
              c_we     <= req_we;
              c_inst   <= req_inst;
              c_wdata  <= req_wdata;
              c_second <= 1'b0;
              st       <= S_P0;
            end
          end
        end
        S_HOLD: if (!hold_i) st <= S_IDLE;
        S_P0:   st <= S_P1;
        S_P1: begin
          c_wide <= cfg_dyn_width && buswidth_i;
          st     <= S_P2;
        end
        S_P2, S_WB: st <= ready_i ? S_P3 : S_WA;
        S_WA:       st <= S_WB;
        S_P3: begin
          if (!c_we) begin
            if (c_wide)  rdata_o             <= ad_i;
            else if (a0) rdata_o[DW-1:BW]    <= ad_i[BW-1:0];
            else         rdata_o[BW-1:0]     <= ad_i[BW-1:0];
          end
          if (!c_wide && !c_second && c_be == 2'b11) begin
            c_second  <= 1'b1;
            c_addr[0] <= 1'b1;
            st        <= S_P0;
          end else begin
            ack_o <= 1'b1;
            st    <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbus_ctl_chk.sv
module xbus_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_adv,
  input logic cfg_dyn_width,
  input logic cfg_wrh,
  input logic ack_o,
  input logic int_hit_o,
  input logic ad_oe_o,
  input logic addr_strb_o,
  input logic rd_n_o,
  input logic wr_n_o,
  input logic bhe_n_o,
  input logic inst_o,
  input logic hlda_o,
  input logic breq_o,
  input logic weak_o
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n_o && !wr_n_o)); // R13
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ack_o |=> !ack_o); // R13
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) hlda_o |-> (rd_n_o && wr_n_o && bhe_n_o && !ad_oe_o && !inst_o && weak_o)); // R11
  AST_HLDA_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) $rose(hlda_o) |-> $past(rd_n_o && wr_n_o && !ad_oe_o)); // R11
  AST_BREQ_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) breq_o |-> hlda_o); // R12
  AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (ack_o && int_hit_o) |-> $past(!ad_oe_o && rd_n_o && wr_n_o)); // R9
  AST_NARROW_NO_HILANE: assert property (@(posedge clk) disable iff (!rst_n) (!cfg_dyn_width && !cfg_wrh) |-> bhe_n_o); // R1
  AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) (!cfg_adv && addr_strb_o) |=> !addr_strb_o); // R5
endmodule

bind xbus_ctl xbus_ctl_chk u_chk (.*);

// File: tb/xbus_ctl_tb.sv
module xbus_ctl_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_dyn_width = 1'b0, cfg_adv = 1'b0, cfg_wrl = 1'b0, cfg_wrh = 1'b0, ea_i = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_inst = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic ack_o, int_hit_o, ad_oe_o, addr_strb_o, rd_n_o, wr_n_o, bhe_n_o, inst_o;
  logic hlda_o, breq_o, weak_o;
  logic [15:0] rdata_o, ad_o, ad_i;
  logic buswidth_i = 1'b0, ready_i, hold_i = 1'b0;

  xbus_ctl u_dut (.*);

  int checks = 0, fails = 0;
  int thr = 0;

  function automatic logic [7:0] mb(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  logic [15:0] la = '0, first_la = '0, last_la = '0;
  logic [7:0]  w_first = '0, w_last = '0;
  logic prev_as = 1'b0, mon_clr = 1'b0;
  int c_rd = 0, n_as = 0, n_rd = 0, n_wr = 0, n_bhe = 0, n_inst = 0, n_asl = 0, n_wd = 0, n_hlda = 0;

  assign ad_i    = {mb({la[15:1], 1'b1}), mb(la)};
  assign ready_i = (c_rd >= thr);

  always @(posedge clk) begin
    prev_as <= addr_strb_o;
    c_rd    <= rd_n_o ? 0 : c_rd + 1;
    if (cfg_adv ? (prev_as && !addr_strb_o) : addr_strb_o) la <= ad_o;
    if (mon_clr) begin
      n_as <= 0; n_rd <= 0; n_wr <= 0; n_bhe <= 0; n_inst <= 0; n_asl <= 0; n_wd <= 0; n_hlda <= 0;
    end else begin
      if (cfg_adv ? (prev_as && !addr_strb_o) : addr_strb_o) begin
        if (n_as == 0) first_la <= ad_o;
        last_la <= ad_o;
        n_as <= n_as + 1;
      end
      if (!rd_n_o) n_rd <= n_rd + 1;
      if (!wr_n_o) n_wr <= n_wr + 1;
      if (!bhe_n_o) n_bhe <= n_bhe + 1;
      if (inst_o) n_inst <= n_inst + 1;
      if (!addr_strb_o) n_asl <= n_asl + 1;
      if (hlda_o) n_hlda <= n_hlda + 1;
      if (!wr_n_o || !bhe_n_o) begin
        if (n_wd == 0) w_first <= ad_o[7:0];
        w_last <= ad_o[7:0];
        n_wd <= n_wd + 1;
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic inst, input logic [15:0] addr,
                        input logic [1:0] be, input logic [15:0] wd, output int lat);
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
    req_valid = 1'b1; req_we = we; req_inst = inst; req_addr = addr; req_be = be; req_wdata = wd;
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!ack_o && lat < 300);
    req_valid = 1'b0;
  endtask

  task automatic set_cfg(input logic dyn, input logic adv, input logic wrl, input logic wrh, input logic bw);
    @(negedge clk);
    cfg_dyn_width = dyn; cfg_adv = adv; cfg_wrl = wrl; cfg_wrh = wrh; buswidth_i = bw;
  endtask

  task automatic t_reset;
    chk("R13 rd_n reset", rd_n_o, 1);
    chk("R13 wr_n reset", wr_n_o, 1);
    chk("R13 bhe_n reset", bhe_n_o, 1);
    chk("R13 ack reset", ack_o, 0);
    chk("R11 hlda reset", hlda_o, 0);
    chk("R5 ale reset", addr_strb_o, 0);
    chk("R13 oe reset", ad_oe_o, 0);
  endtask

  task automatic t_narrow_read;
    int lat;
    set_cfg(0, 0, 0, 0, 1);
    access(0, 0, 16'h8000, 2'b11, 0, lat);
    chk("R1 split latency", lat, 9);
    chk("R1 two cycles", n_as, 2);
    chk("R1 even addr first", first_la, 16'h8000);
    chk("R1 odd addr second", last_la, 16'h8001);
    chk("R1 assembled data", rdata_o, {mb(16'h8001), mb(16'h8000)});
    chk("R4 rd low clocks split", n_rd, 6);
    access(0, 0, 16'h8004, 2'b10, 0, lat);
    chk("R1 odd byte one cycle", n_as, 1);
    chk("R5 odd address bit0", first_la, 16'h8005);
    chk("R1 odd byte lane", rdata_o[15:8], mb(16'h8005));
  endtask

  task automatic t_dyn_width;
    int lat;
    set_cfg(1, 0, 0, 0, 1);
    access(0, 0, 16'h8002, 2'b11, 0, lat);
    chk("R2 wide latency", lat, 5);
    chk("R2 wide one cycle", n_as, 1);
    chk("R2 wide data", rdata_o, {mb(16'h8003), mb(16'h8002)});
    chk("R4 rd low zero wait", n_rd, 3);
    set_cfg(1, 0, 0, 0, 0);
    access(0, 0, 16'h8006, 2'b11, 0, lat);
    chk("R3 narrow by pin latency", lat, 9);
    chk("R3 narrow by pin cycles", n_as, 2);
    chk("R3 narrow by pin data", rdata_o, {mb(16'h8007), mb(16'h8006)});
  endtask

  task automatic t_waits;
    int lat;
    set_cfg(1, 0, 0, 0, 1);
    thr = 2;
    access(0, 0, 16'h8008, 2'b11, 0, lat);
    chk("R4 one wait latency", lat, 7);
    chk("R4 one wait rd clocks", n_rd, 5);
    thr = 6;
    access(0, 0, 16'h800A, 2'b11, 0, lat);
    chk("R4 three wait latency", lat, 11);
    chk("R4 three wait rd clocks", n_rd, 9);
    chk("R4 data after waits", rdata_o, {mb(16'h800B), mb(16'h800A)});
    thr = 0;
  endtask

  task automatic t_adv;
    int lat;
    set_cfg(1, 1, 0, 0, 1);
    access(0, 0, 16'h8020, 2'b11, 0, lat);
    chk("R5 adv one fall", n_as, 1);
    chk("R5 adv low clocks", n_asl, 3);
    chk("R5 adv high idle", addr_strb_o, 1);
    chk("R5 adv data", rdata_o, {mb(16'h8021), mb(16'h8020)});
    set_cfg(0, 1, 0, 0, 1);
    access(0, 0, 16'h8030, 2'b11, 0, lat);
    chk("R5 adv rises between halves", n_as, 2);
    chk("R5 adv split low clocks", n_asl, 6);
    chk("R5 adv split data", rdata_o, {mb(16'h8031), mb(16'h8030)});
  endtask

  task automatic t_writes;
    int lat;
    set_cfg(0, 0, 0, 0, 1);
    access(1, 0, 16'h9000, 2'b11, 16'hBEEF, lat);
    chk("R6 wr every narrow cycle", n_wr, 4);
    chk("R7 bhe idle narrow", n_bhe, 0);
    chk("R1 write even byte first", w_first, 8'hEF);
    chk("R1 write odd byte on low lane", w_last, 8'hBE);
    chk("R1 write latency", lat, 9);
    set_cfg(0, 0, 1, 1, 1);
    access(1, 0, 16'h9000, 2'b11, 16'h1234, lat);
    chk("R6 wrl narrow even only", n_wr, 2);
    chk("R7 wrh narrow odd only", n_bhe, 2);
    set_cfg(1, 0, 1, 1, 1);
    access(1, 0, 16'h9000, 2'b10, 16'hA55A, lat);
    chk("R6 wrl odd-only write", n_wr, 0);
    chk("R7 wrh odd-only write", n_bhe, 2);
    chk("R5 odd write address", first_la, 16'h9001);
    access(1, 0, 16'h9000, 2'b01, 16'hA55A, lat);
    chk("R6 wrl even-only write", n_wr, 2);
    chk("R7 wrh even-only write", n_bhe, 0);
    chk("R2 wide write lane", w_last, 8'h5A);
    set_cfg(1, 0, 0, 0, 1);
    access(1, 0, 16'h9000, 2'b11, 16'hC3C3, lat);
    chk("R6 wr wide write", n_wr, 2);
    chk("R7 bhe upper lane", n_bhe, 2);
    access(1, 0, 16'h9000, 2'b01, 16'hC3C3, lat);
    chk("R7 bhe no upper lane", n_bhe, 0);
    chk("R13 no rd in write", n_rd, 0);
  endtask

  task automatic t_inst;
    int lat;
    set_cfg(1, 0, 0, 0, 1);
    access(0, 1, 16'h8000, 2'b11, 0, lat);
    chk("R8 inst whole fetch", n_inst, 4);
    access(0, 0, 16'h8000, 2'b11, 0, lat);
    chk("R8 inst low data read", n_inst, 0);
    access(1, 1, 16'h8000, 2'b11, 0, lat);
    chk("R8 inst low write", n_inst, 0);
  endtask

  task automatic t_internal;
    int lat;
    set_cfg(1, 0, 0, 0, 1);
    ea_i = 1'b1;
    access(0, 0, 16'h3000, 2'b11, 0, lat);
    chk("R9 on-chip latency", lat, 1);
    chk("R9 on-chip flag", int_hit_o, 1);
    chk("R9 no strobe", n_as + n_rd, 0);
    access(0, 1, 16'h5FFE, 2'b11, 0, lat);
    chk("R9 top of range on-chip", int_hit_o, 1);
    access(0, 0, 16'h6000, 2'b11, 0, lat);
    chk("R9 above range off-chip", lat, 5);
    chk("R9 above range flag", int_hit_o, 0);
    access(0, 0, 16'h1FFE, 2'b11, 0, lat);
    chk("R9 below range off-chip", n_as, 1);
    ea_i = 1'b0;
    access(0, 0, 16'h3000, 2'b11, 0, lat);
    chk("R9 ea low off-chip", lat, 5);
    chk("R9 ea low flag", int_hit_o, 0);
    access(0, 0, 16'h01FE, 2'b11, 0, lat);
    chk("R10 register data on-chip", int_hit_o, 1);
    chk("R10 register data latency", lat, 1);
    access(0, 1, 16'h0100, 2'b11, 0, lat);
    chk("R10 low code fetch off-chip", int_hit_o, 0);
    chk("R10 low code fetch cycles", n_as, 1);
    access(0, 0, 16'h0200, 2'b11, 0, lat);
    chk("R10 above registers off-chip", n_as, 1);
  endtask

  task automatic t_hold_idle;
    int n;
    set_cfg(1, 0, 0, 0, 1);
    @(negedge clk); hold_i = 1'b1;
    @(negedge clk);
    chk("R11 hlda granted", hlda_o, 1);
    chk("R11 weak park", weak_o, 1);
    chk("R11 bus floated", ad_oe_o, 0);
    chk("R11 strobes inactive", {rd_n_o, wr_n_o, bhe_n_o, addr_strb_o, inst_o}, 5'b11100);
    chk("R12 no breq without request", breq_o, 0);
    req_valid = 1'b1; req_we = 1'b0; req_inst = 1'b0; req_addr = 16'h3000; req_be = 2'b11; ea_i = 1'b1;
    @(negedge clk);
    chk("R12 no breq for on-chip", breq_o, 0);
    req_addr = 16'h8040; ea_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 breq pending", breq_o, 1);
    chk("R11 no cycle in hold", {ack_o, addr_strb_o}, 2'b00);
    hold_i = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!ack_o && n < 50);
    req_valid = 1'b0;
    chk("R11 served after release", n, 6);
    chk("R12 breq gone", breq_o, 0);
    chk("R11 data after release", rdata_o, {mb(16'h8041), mb(16'h8040)});
  endtask

  task automatic t_hold_mid;
    int lat;
    set_cfg(0, 0, 0, 0, 1);
    fork
      access(0, 0, 16'h8050, 2'b11, 0, lat);
      begin repeat (4) @(negedge clk); hold_i = 1'b1; end
    join
    chk("R11 split not cut", lat, 9);
    chk("R11 no grant inside", n_hlda, 0);
    chk("R11 data intact", rdata_o, {mb(16'h8051), mb(16'h8050)});
    @(negedge clk);
    chk("R11 grant at boundary", hlda_o, 1);
    hold_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 release", hlda_o, 0);
  endtask

  initial begin
    #500us;
    fails++;
    $display("FAIL R13 watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow_read();
    t_dyn_width();
    t_waits();
    t_adv();
    t_writes();
    t_inst();
    t_internal();
    t_hold_idle();
    t_hold_mid();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule